// File: doc/BRIEF.md
# Bit-Serial Constant-Operand Galois Field Multiplier

This block forms the product of a fixed field element and a variable one in GF(2^M), M = 4 by default, with elements written in polynomial basis. The fixed factor and the reduction polynomial are set at elaboration; the variable factor `b` is captured on a start strobe and consumed one bit per clock, most significant bit first. Each clock performs one Horner step: the accumulator is multiplied by x, reduced by the field polynomial, and the constant is XORed in when the current bit of `b` is set. Field addition is bitwise XOR throughout.

A parameter picks how the constant factor is realised. In folded mode each bit cell is generated from the constant and polynomial bits as pure XOR wiring with no AND gate. In held mode the constant sits in a register loaded at reset and each cell gates it with the current bit of `b`. Both modes produce the same products with the same timing.

After M processing clocks the product register is updated and `done` pulses for one cycle. The product then holds until the next operation completes. A strobe that arrives while an operation is running is ignored.

Top module: `gf_serial_mul`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), on each clock edge `product` is cleared to 0 and `done` to 0, and any running operation is abandoned.
- R2: A start accepted at clock edge E0 (start high while idle) yields, after edge E0+M, `done` high and `product` equal to A_CONST·b mod POLY, where b is the value on `b` at E0, the product is the carry-less polynomial product of the two 4-bit values (bit i = coefficient of x^i) reduced by POLY (bit i = coefficient of x^i, bit M set).
- R3: `done` is high for exactly one cycle per accepted start.
- R4: A start that is high while an operation is running is ignored: the running result, its `done` timing and the number of `done` pulses are unchanged.
- R5: Between completions `product` keeps its last value.
- R6: A start raised in the same cycle that `done` is high is accepted, giving back-to-back operations every M+1 cycles.
- R7: Folded mode (CMODE = CONST_FOLDED) and held mode (CMODE = CONST_HELD) give identical products and timing.
- R8: `b` is sampled only at the accepting edge; changes on `b` during an operation do not affect its result.
- R9: A non-default field polynomial such as x^4+x^3+1 (POLY = 5'h19) is honoured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start strobe, accepted only while idle |
| b | input | M | Variable factor, captured at an accepted start |
| product | output | M | Last completed product, held between operations |
| done | output | 1 | One-cycle pulse when `product` has just been updated |

## Verification
The hardest situation to reach from the ports is a strobe landing in the middle of a running operation together with a change of `b`, since an accepted second strobe would only show as a wrong value or a second pulse several cycles later. The stimulus raises `start` with a different `b` two cycles into an operation, then watches the first result and the following cycles for any extra pulse. Every value of `b` is swept on five instances at once, covering several constants, both constant modes and two field polynomials, against an arithmetic carry-less multiply-and-reduce model; a back-to-back start in the `done` cycle is also driven.

// File: rtl/gfsm_pkg.sv
// Package: shared types and defaults for the bit-serial GF multiplier.
// Assumes field widths from 2 to 8 bits; polynomial includes the x^M term.
package gfsm_pkg;

    // How the constant factor is built into the bit cells.
    typedef enum logic {
        CONST_HELD   = 1'b0,
        CONST_FOLDED = 1'b1
    } const_mode_e;

    localparam int          DEF_WIDTH = 4;
    localparam logic [4:0]  DEF_POLY  = 5'h13;  // x^4 + x + 1
    localparam logic [3:0]  DEF_CONST = 4'hB;   // x^3 + x + 1

endpackage

// File: rtl/gfsm_cell.sv
// Module: one accumulator bit of the Horner step.
// Computes nxt = lower ^ (top & PBIT) ^ (bbit & a), where lower is the
// next-lower accumulator bit (0 for bit 0), top is the accumulator MSB.
// PBIT is always constant; in folded mode ABIT is constant too, so the
// cell is generated as XOR wiring only. In held mode a_bit comes from a
// register and one AND gate remains.
module gfsm_cell
    import gfsm_pkg::*;
#(
    parameter const_mode_e CMODE = CONST_FOLDED,
    parameter logic        PBIT  = 1'b0,
    parameter logic        ABIT  = 1'b0
) (
    input  logic lower,
    input  logic top,
    input  logic bbit,
    input  logic a_bit,
    output logic nxt
);

    logic red_term;
    logic add_term;

    // Reduction term: the fixed polynomial bit decides wiring.
    generate
        if (PBIT) begin : g_red_on
            assign red_term = top;
        end else begin : g_red_off
            assign red_term = 1'b0;
        end
    endgenerate

    // Constant-add term: folded to wiring or gated with a register bit.
    generate
        if (CMODE == CONST_FOLDED) begin : g_fold
            logic unused_a;
            assign unused_a = a_bit;
            if (ABIT) begin : g_add_on
                assign add_term = bbit;
            end else begin : g_add_off
                assign add_term = 1'b0;
            end
        end else begin : g_held
            assign add_term = bbit & a_bit;
        end
    endgenerate

    // Field addition is XOR.
    assign nxt = lower ^ red_term ^ add_term;

endmodule

// File: rtl/gfsm_ctrl.sv
// Module: sequencing for one multiply.
// Accepts a start only while idle, counts M processing steps, flags the
// final step and registers a one-cycle done pulse. Assumes M >= 2.
module gfsm_ctrl #(
    parameter int M = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(M + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Decode of the step counter.
    always_comb begin
        busy = (cnt_q != '0);
        load = start && !busy;
        step = busy;
        last = busy && (cnt_q == CW'(1));
    end

    // Step counter and done pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (load) begin
                cnt_q <= CW'(M);
            end else if (busy) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign done = done_q;

endmodule

// File: rtl/gfsm_datapath.sv
// Module: operand shift register, Horner accumulator and product register.
// On load the operand is captured and the accumulator cleared; on each
// step the MSB of the shift register drives one Horner step; on the last
// step the result is copied to the product register, which then holds.
module gfsm_datapath
    import gfsm_pkg::*;
#(
    parameter int          M       = 4,
    parameter logic [M:0]  POLY    = gfsm_pkg::DEF_POLY,
    parameter logic [M-1:0] A_CONST = gfsm_pkg::DEF_CONST,
    parameter const_mode_e CMODE   = CONST_FOLDED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         last,
    input  logic [M-1:0] b,
    output logic [M-1:0] product
);

    logic [M-1:0] bsh_q;
    logic [M-1:0] acc_q;
    logic [M-1:0] prod_q;
    logic [M-1:0] a_vec;
    logic [M-1:0] nxt;
    logic [M:0]   lower_vec;
    logic         bbit;

    assign bbit      = bsh_q[M-1];
    assign lower_vec = {acc_q, 1'b0};

    // Source of the constant factor: wiring or a reset-loaded register.
    generate
        if (CMODE == CONST_HELD) begin : g_areg
            logic [M-1:0] a_q;
            // Constant register, loaded at reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    a_q <= A_CONST;
                end else begin
                    a_q <= a_q;
                end
            end
            assign a_vec = a_q;
        end else begin : g_awire
            assign a_vec = A_CONST;
        end
    endgenerate

    // One Horner cell per accumulator bit.
    generate
        for (genvar i = 0; i < M; i++) begin : g_cell
            gfsm_cell #(
                .CMODE (CMODE),
                .PBIT  (POLY[i]),
                .ABIT  (A_CONST[i])
            ) u_cell (
                .lower (lower_vec[i]),
                .top   (acc_q[M-1]),
                .bbit  (bbit),
                .a_bit (a_vec[i]),
                .nxt   (nxt[i])
            );
        end
    endgenerate

    // Operand capture, Horner accumulation and product update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsh_q  <= '0;
            acc_q  <= '0;
            prod_q <= '0;
        end else begin
            if (load) begin
                bsh_q <= b;
                acc_q <= '0;
            end else if (step) begin
                bsh_q <= {bsh_q[M-2:0], 1'b0};
                acc_q <= nxt;
            end
            if (last) begin
                prod_q <= nxt;
            end
        end
    end

    assign product = prod_q;

endmodule

// File: rtl/gf_serial_mul.sv
// Module: top of the bit-serial constant-operand GF(2^M) multiplier.
// Multiplies A_CONST by b modulo POLY, one bit of b per clock, MSB first.
// Assumes POLY has bit M set and 2 <= M <= 8.
module gf_serial_mul
    import gfsm_pkg::*;
#(
    parameter int           M       = gfsm_pkg::DEF_WIDTH,
    parameter logic [M:0]   POLY    = gfsm_pkg::DEF_POLY,
    parameter logic [M-1:0] A_CONST = gfsm_pkg::DEF_CONST,
    parameter const_mode_e  CMODE   = CONST_FOLDED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] b,
    output logic [M-1:0] product,
    output logic         done
);

    logic load;
    logic step;
    logic last;
    logic busy;

    gfsm_ctrl #(
        .M (M)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    gfsm_datapath #(
        .M       (M),
        .POLY    (POLY),
        .A_CONST (A_CONST),
        .CMODE   (CMODE)
    ) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .last    (last),
        .b       (b),
        .product (product)
    );

endmodule

// File: rtl/gfsm_chk.sv
// Module: property checker for gf_serial_mul, attached by bind.
// Tracks accepted starts with its own cycle counter and checks reset
// values, pulse width, completion latency and product hold.
module gfsm_chk #(
    parameter int M = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [M-1:0] product
);

    localparam int TW = $clog2(M + 2);

    logic          was_rst;
    logic [TW-1:0] since_q;

    // Remember whether the previous edge was in reset.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
    end

    // Cycles since the last accepted start, saturating above M.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= TW'(M + 1);
        end else if (start && !busy) begin
            since_q <= '0;
        end else if (since_q <= TW'(M)) begin
            since_q <= since_q + TW'(1);
        end
    end

    // R1
    always_ff @(posedge clk) begin
        if (was_rst === 1'b1) begin
            reset_clear_chk: assert (product == '0 && !done)
                else $error("reset did not clear outputs");
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_q == TW'(M)));

    // R5
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !was_rst) |-> $stable(product));

endmodule

bind gf_serial_mul gfsm_chk #(.M(M)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/sim_gf_serial_mul.sv
// Bench: five multiplier instances driven in parallel, swept over every b.
module sim_gf_serial_mul;
    import gfsm_pkg::*;

    localparam int NI = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [3:0] b;
    logic [3:0] prod [NI];
    logic       dn   [NI];

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // Instance constants and polynomials, indexed like prod/dn.
    function automatic logic [3:0] a_of(input int k);
        case (k)
            0: return 4'hB;
            1: return 4'hB;
            2: return 4'h1;
            3: return 4'hF;
            default: return 4'h8;
        endcase
    endfunction

    function automatic logic [4:0] p_of(input int k);
        return (k == 3) ? 5'h19 : 5'h13;
    endfunction

    // Carry-less multiply, then reduce from the top bit down.
    function automatic logic [3:0] ref_mul(input logic [3:0] a,
                                           input logic [3:0] bb,
                                           input logic [4:0] p);
        logic [6:0] w;
        w = '0;
        for (int i = 0; i < 4; i++)
            if (bb[i]) w = w ^ ({3'b000, a} << i);
        for (int k = 6; k >= 4; k--)
            if (w[k]) w = w ^ ({2'b00, p} << (k - 4));
        return w[3:0];
    endfunction

    gf_serial_mul #(.A_CONST(4'hB), .POLY(5'h13), .CMODE(CONST_FOLDED)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .b(b), .product(prod[0]), .done(dn[0]));
    gf_serial_mul #(.A_CONST(4'hB), .POLY(5'h13), .CMODE(CONST_HELD)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .b(b), .product(prod[1]), .done(dn[1]));
    gf_serial_mul #(.A_CONST(4'h1), .POLY(5'h13), .CMODE(CONST_FOLDED)) u2 (
        .clk(clk), .rst_n(rst_n), .start(start), .b(b), .product(prod[2]), .done(dn[2]));
    gf_serial_mul #(.A_CONST(4'hF), .POLY(5'h19), .CMODE(CONST_HELD)) u3 (
        .clk(clk), .rst_n(rst_n), .start(start), .b(b), .product(prod[3]), .done(dn[3]));
    gf_serial_mul #(.A_CONST(4'h8), .POLY(5'h13), .CMODE(CONST_FOLDED)) u4 (
        .clk(clk), .rst_n(rst_n), .start(start), .b(b), .product(prod[4]), .done(dn[4]));

    task automatic check(input bit ok, input string tag, input int k,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s inst u%0d actual=%0h expected=%0h", tag, k, act, exp);
        end
    endtask

    task automatic chk_done(input logic want, input string tag);
        for (int k = 0; k < NI; k++)
            check(dn[k] == want, tag, k, int'(dn[k]), int'(want));
    endtask

    task automatic chk_prod(input logic [3:0] bv, input string tag);
        for (int k = 0; k < NI; k++) begin
            logic [3:0] e;
            e = ref_mul(a_of(k), bv, p_of(k));
            check(prod[k] == e, tag, k, int'(prod[k]), int'(e));
        end
    endtask

    // Present start with bv, return at the negedge after acceptance.
    task automatic op_begin(input logic [3:0] bv);
        start = 1'b1;
        b     = bv;
        @(negedge clk);
        start = 1'b0;
    endtask

    // No done for 4 cycles, then done and the product.
    task automatic op_end(input logic [3:0] bv, input string tag);
        for (int i = 0; i < 4; i++) begin
            chk_done(1'b0, {tag, " early done"});
            @(negedge clk);
        end
        chk_done(1'b1, {tag, " done"});
        chk_prod(bv, {tag, " product"});
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        b     = 4'h0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared in reset
        chk_done(1'b0, "R1 reset done");
        for (int k = 0; k < NI; k++)
            check(prod[k] == 4'h0, "R1 reset product", k, int'(prod[k]), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R7 R9: exhaustive sweep over b; R3 R5 after each result
        for (int v = 0; v < 16; v++) begin
            op_begin(4'(v));
            op_end(4'(v), "R2 sweep");
            @(negedge clk);
            chk_done(1'b0, "R3 pulse width");
            chk_prod(4'(v), "R5 hold");
            @(negedge clk);
        end

        // R4 R8: start with new b two cycles into a running operation
        op_begin(4'h5);
        @(negedge clk);
        start = 1'b1;
        b     = 4'hA;
        @(negedge clk);
        start = 1'b0;
        b     = 4'h6;
        @(negedge clk);
        @(negedge clk);
        chk_done(1'b1, "R4 done timing");
        chk_prod(4'h5, "R8 b sampled at start");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk_done(1'b0, "R4 no extra done");
            chk_prod(4'h5, "R4 product kept");
        end

        // R6: start raised in the done cycle is accepted
        op_begin(4'h3);
        op_end(4'h3, "R6 first");
        op_begin(4'hC);
        op_end(4'hC, "R6 back-to-back");
        @(negedge clk);
        chk_done(1'b0, "R3 pulse width b2b");

        // R1: reset mid-operation abandons it
        op_begin(4'h9);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            chk_done(1'b0, "R1 abandoned op");
            for (int k = 0; k < NI; k++)
                check(prod[k] == 4'h0, "R1 product after reset", k, int'(prod[k]), 0);
            @(negedge clk);
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule